// File: doc/BRIEF.md
# Partitioned Virtual FIFO Bank

This block is a dual-clock buffer that divides one shared word store into as many as eight circular queues, one per port. A receive-side producer writes 32-bit words, each with an 8-bit control tag, into the queue named by a port number. The consumer runs on its own clock. It pulls one, two or four entries per access, so its bus is 32, 64 or 128 bits wide, and the tags come out alongside the data. Pointers cross between the clocks as Gray code through two-flop synchronizers.

The partition count is a static setting captured while the bank is held in reset. Fewer active ports give each port a larger slice of the store. With `rd_en` low, the consumer can present any port number on `rd_port` and see that queue's fill level and empty flag without removing anything. The empty flag has two modes: it can mean truly empty, or below one quarter of the partition.

The consumer side is a three-state machine that records the outcome of the previous cycle's request:
- `RD_IDLE`: no request was made, which is a poll.
- `RD_SERVE`: a request was granted.
- `RD_REFUSE`: a request was declined because too few entries were present.

From any state, `rd_en` low leads to `RD_IDLE`. `rd_en` high with enough entries leads to `RD_SERVE`. `rd_en` high with too few entries leads to `RD_REFUSE`.

Top module: `vfb_bank`

## Requirements
- R1: `cfg_ports` = n (0..3), sampled while both resets are low, makes ports 0..2^n-1 active. Each active port owns 64>>n entries starting at entry p*(64>>n). Each queue is first-in first-out and does not affect the others.
- R2: A write to a port number of 2^n or above is discarded. No level, full flag or overflow bit changes.
- R3: `wr_full[p]` is high when port p holds its whole partition. A write to a full port is discarded and sets `wr_ovf[p]`. `wr_ovf[p]` stays set until the write-side reset.
- R4: `rd_width` 0 takes 1 entry, 1 takes 2 entries, and 2 or 3 takes 4 entries. A granted request raises `rd_valid` after the next `rclk` edge. The oldest entry goes in lane 0: data bits 31:0 and tag bits 7:0. Lane i uses data bits 32i+31:32i and tag bits 8i+7:8i. Unused lanes read zero.
- R5: A request for more entries than the port holds raises `rd_refused` after the next edge. `rd_data`, `rd_ctl` and the port's level stay unchanged.
- R6: With `rd_en` low, `stat_level` and `stat_empty` show the queue selected by `rd_port`, and no entry is consumed. After that edge, `rd_valid` and `rd_refused` are both low.
- R7: With `cfg_qtr` = 0 (captured in reset), `stat_empty` is high only at level 0. With `cfg_qtr` = 1, it is high while the level is below one quarter of the partition size.
- R8: A word shows in `stat_level` by the fourth `rclk` edge, counting the edge that wrote it. Space freed by a read clears `wr_full` within five `wclk` edges.
- R9: After reset, all levels are 0, `stat_empty` = 1, and `wr_full`, `wr_ovf`, `rd_valid`, `rd_refused`, `rd_data` and `rd_ctl` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side reset, active low |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side reset, active low |
| cfg_ports | input | 2 | log2 of the active port count, captured in reset |
| cfg_qtr | input | 1 | Empty-flag mode (1 = below quarter), captured in reset |
| wr_en | input | 1 | Write strobe |
| wr_port | input | 3 | Destination queue |
| wr_data | input | 32 | Word to store |
| wr_ctl | input | 8 | Tag stored with the word |
| wr_full | output | 8 | Per-port full flags |
| wr_ovf | output | 8 | Per-port sticky overflow bits |
| rd_en | input | 1 | Read request; low means poll only |
| rd_port | input | 3 | Queue to read or poll |
| rd_width | input | 2 | Entries per request (0:1, 1:2, 2/3:4) |
| rd_data | output | 128 | Delivered words, oldest in the low lane |
| rd_ctl | output | 32 | Delivered tags, one byte per lane |
| rd_valid | output | 1 | Previous request granted |
| rd_refused | output | 1 | Previous request refused |
| stat_level | output | 7 | Fill level of the queue on `rd_port` |
| stat_empty | output | 1 | Empty flag of the queue on `rd_port` |

## Verification
A write and a read can land on the same full partition in the same cycle. The bench fills port 6, then raises a 32-bit read and a write to that port together. Because the freed slot has not yet crossed to the write clock, the write must be dropped and flag overflow while the read still delivers the oldest word. The level is judged after the pointers settle: it must be seven, not eight. Polling while writes land is also exercised: a queue is polled for several cycles and must then still hand out its first word.

// File: rtl/vfb_pkg.sv
package vfb_pkg;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_SERVE  = 2'd1,
        RD_REFUSE = 2'd2
    } rd_state_e;

    // entries taken by one read for a given width code
    function automatic logic [2:0] lane_need(input logic [1:0] w);
        unique case (w)
            2'd0:    lane_need = 3'd1;
            2'd1:    lane_need = 3'd2;
            default: lane_need = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/vfb_sync.sv
module vfb_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/vfb_ram.sv
module vfb_ram #(
    parameter int DEPTH = 64,
    parameter int EW    = 40,
    parameter int NRD   = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [EW-1:0]     wdata,
    input  logic [NRD*AW-1:0] raddr,
    output logic [NRD*EW-1:0] rdata
);
    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    generate
        for (genvar i = 0; i < NRD; i++) begin : g_rd
            assign rdata[i*EW +: EW] = mem[raddr[i*AW +: AW]];
        end
    endgenerate
endmodule

// File: rtl/vfb_wr_side.sv
module vfb_wr_side #(
    parameter int NPORT  = 8,
    parameter int DEPTH  = 64,
    parameter int DW     = 32,
    parameter int CW     = 8,
    localparam int PSW   = $clog2(NPORT),
    localparam int CFGW  = $clog2(PSW + 1),
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic                wclk,
    input  logic                wrst_n,
    input  logic [CFGW-1:0]     cfg_ports,
    input  logic                wr_en,
    input  logic [PSW-1:0]      wr_port,
    input  logic [DW-1:0]       wr_data,
    input  logic [CW-1:0]       wr_ctl,
    input  logic [NPORT*PW-1:0] rgray_s,
    output logic [NPORT*PW-1:0] wgray,
    output logic                mem_we,
    output logic [AW-1:0]       mem_waddr,
    output logic [DW+CW-1:0]    mem_wdata,
    output logic [NPORT-1:0]    wr_full,
    output logic [NPORT-1:0]    wr_ovf
);
    logic [CFGW-1:0] cfg_q;
    logic [PW-1:0]   psize, pmask, base;
    logic [PSW:0]    nact;
    logic            port_ok, accept;
    logic [PW-1:0]   wptr [NPORT];
    logic [PW-1:0]   wg   [NPORT];

    // partition setting only moves while the write side is in reset
    always_ff @(posedge wclk) begin
        if (!wrst_n) cfg_q <= cfg_ports;
    end

    assign psize   = PW'(DEPTH) >> cfg_q;
    assign pmask   = psize - PW'(1);
    assign nact    = (PSW+1)'(1) << cfg_q;
    assign port_ok = {1'b0, wr_port} < nact;
    assign accept  = wr_en && port_ok && !wr_full[wr_port];
    assign base    = PW'(wr_port) * psize;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            logic [PW-1:0] rg, rb;
            assign rg = rgray_s[p*PW +: PW];
            always_comb begin
                for (int i = 0; i < PW; i++) rb[i] = ^(rg >> i);
            end
            assign wr_full[p]          = (wptr[p] - rb) >= psize;
            assign wgray[p*PW +: PW]   = wg[p];

            assert_ovf_sticky_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
                wr_ovf[p] |=> wr_ovf[p]);
        end
    endgenerate

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            for (int p = 0; p < NPORT; p++) begin
                wptr[p] <= '0;
                wg[p]   <= '0;
            end
            wr_ovf <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) wg[p] <= wptr[p] ^ (wptr[p] >> 1);
            if (accept) wptr[wr_port] <= wptr[wr_port] + PW'(1);
            if (wr_en && port_ok && wr_full[wr_port]) wr_ovf[wr_port] <= 1'b1;
        end
    end

    assign mem_we    = accept;
    assign mem_waddr = AW'(base + (wptr[wr_port] & pmask));
    assign mem_wdata = {wr_ctl, wr_data};

    assert_full_drop_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_en && port_ok && wr_full[wr_port]) |=> wr_ovf[$past(wr_port)]);

    assert_inactive_R2: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_en && !port_ok) |-> !mem_we);
endmodule

// File: rtl/vfb_rd_side.sv
module vfb_rd_side import vfb_pkg::*; #(
    parameter int NPORT  = 8,
    parameter int DEPTH  = 64,
    parameter int DW     = 32,
    parameter int CW     = 8,
    localparam int PSW   = $clog2(NPORT),
    localparam int CFGW  = $clog2(PSW + 1),
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1,
    localparam int LANES = 4,
    localparam int EW    = DW + CW
) (
    input  logic                rclk,
    input  logic                rrst_n,
    input  logic [CFGW-1:0]     cfg_ports,
    input  logic                cfg_qtr,
    input  logic                rd_en,
    input  logic [PSW-1:0]      rd_port,
    input  logic [1:0]          rd_width,
    input  logic [NPORT*PW-1:0] wgray_s,
    output logic [NPORT*PW-1:0] rgray,
    output logic [LANES*AW-1:0] mem_raddr,
    input  logic [LANES*EW-1:0] mem_rdata,
    output logic [LANES*DW-1:0] rd_data,
    output logic [LANES*CW-1:0] rd_ctl,
    output logic                rd_valid,
    output logic                rd_refused,
    output logic [PW-1:0]       stat_level,
    output logic                stat_empty
);
    rd_state_e       state, nstate;
    logic [CFGW-1:0] cfg_q;
    logic            qtr_q;
    logic [PW-1:0]   psize, pmask, base, need;
    logic            enough;
    logic [PW-1:0]   rptr [NPORT];
    logic [PW-1:0]   rg   [NPORT];
    logic [PW-1:0]   lvl  [NPORT];

    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            cfg_q <= cfg_ports;
            qtr_q <= cfg_qtr;
        end
    end

    assign psize = PW'(DEPTH) >> cfg_q;
    assign pmask = psize - PW'(1);
    assign base  = PW'(rd_port) * psize;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            logic [PW-1:0] wg, wb;
            assign wg = wgray_s[p*PW +: PW];
            always_comb begin
                for (int i = 0; i < PW; i++) wb[i] = ^(wg >> i);
            end
            assign lvl[p]            = wb - rptr[p];
            assign rgray[p*PW +: PW] = rg[p];
        end
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign mem_raddr[i*AW +: AW] = AW'(base + ((rptr[rd_port] + PW'(i)) & pmask));
        end
    endgenerate

    assign stat_level = lvl[rd_port];
    assign stat_empty = qtr_q ? (stat_level < (psize >> 2)) : (stat_level == '0);
    assign need       = PW'(lane_need(rd_width));
    assign enough     = stat_level >= need;

    // state register
    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) state <= RD_IDLE;
        else         state <= nstate;
    end

    always_comb begin
        nstate = RD_IDLE;
        if (rd_en) nstate = enough ? RD_SERVE : RD_REFUSE;
    end

    // outputs decoded from state
    always_comb begin
        rd_valid   = 1'b0;
        rd_refused = 1'b0;
        unique case (state)
            RD_IDLE:   ;
            RD_SERVE:  rd_valid   = 1'b1;
            RD_REFUSE: rd_refused = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            for (int p = 0; p < NPORT; p++) begin
                rptr[p] <= '0;
                rg[p]   <= '0;
            end
            rd_data <= '0;
            rd_ctl  <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) rg[p] <= rptr[p] ^ (rptr[p] >> 1);
            if (rd_en && enough) begin
                rptr[rd_port] <= rptr[rd_port] + need;
                for (int i = 0; i < LANES; i++) begin
                    if (PW'(i) < need) begin
                        rd_data[i*DW +: DW] <= mem_rdata[i*EW +: DW];
                        rd_ctl[i*CW +: CW]  <= mem_rdata[i*EW+DW +: CW];
                    end else begin
                        rd_data[i*DW +: DW] <= '0;
                        rd_ctl[i*CW +: CW]  <= '0;
                    end
                end
            end
        end
    end

    assert_serve_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_en && enough) |=> rd_valid);

    assert_refuse_hold_R5: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_en && !enough) |=> (rd_refused && $stable(rd_data) && $stable(rd_ctl)));

    assert_poll_quiet_R6: assert property (@(posedge rclk) disable iff (!rrst_n)
        !rd_en |=> (!rd_valid && !rd_refused));

    assert_level_bound_R1: assert property (@(posedge rclk) disable iff (!rrst_n)
        stat_level <= psize);
endmodule

// File: rtl/vfb_bank.sv
module vfb_bank #(
    parameter int NPORT  = 8,
    parameter int DEPTH  = 64,
    parameter int DW     = 32,
    parameter int CW     = 8,
    localparam int PSW   = $clog2(NPORT),
    localparam int CFGW  = $clog2(PSW + 1),
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1,
    localparam int LANES = 4,
    localparam int EW    = DW + CW
) (
    input  logic                wclk,
    input  logic                wrst_n,
    input  logic                rclk,
    input  logic                rrst_n,
    input  logic [CFGW-1:0]     cfg_ports,
    input  logic                cfg_qtr,
    input  logic                wr_en,
    input  logic [PSW-1:0]      wr_port,
    input  logic [DW-1:0]       wr_data,
    input  logic [CW-1:0]       wr_ctl,
    output logic [NPORT-1:0]    wr_full,
    output logic [NPORT-1:0]    wr_ovf,
    input  logic                rd_en,
    input  logic [PSW-1:0]      rd_port,
    input  logic [1:0]          rd_width,
    output logic [LANES*DW-1:0] rd_data,
    output logic [LANES*CW-1:0] rd_ctl,
    output logic                rd_valid,
    output logic                rd_refused,
    output logic [PW-1:0]       stat_level,
    output logic                stat_empty
);
    logic [NPORT*PW-1:0] wgray, wgray_s, rgray, rgray_s;
    logic                mem_we;
    logic [AW-1:0]       mem_waddr;
    logic [EW-1:0]       mem_wdata;
    logic [LANES*AW-1:0] mem_raddr;
    logic [LANES*EW-1:0] mem_rdata;

    vfb_wr_side #(.NPORT(NPORT), .DEPTH(DEPTH), .DW(DW), .CW(CW)) u_wr (
        .wclk(wclk), .wrst_n(wrst_n), .cfg_ports(cfg_ports),
        .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data), .wr_ctl(wr_ctl),
        .rgray_s(rgray_s), .wgray(wgray),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .wr_full(wr_full), .wr_ovf(wr_ovf)
    );

    vfb_sync #(.W(NPORT*PW)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
    );

    vfb_sync #(.W(NPORT*PW)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
    );

    vfb_ram #(.DEPTH(DEPTH), .EW(EW), .NRD(LANES)) u_ram (
        .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    vfb_rd_side #(.NPORT(NPORT), .DEPTH(DEPTH), .DW(DW), .CW(CW)) u_rd (
        .rclk(rclk), .rrst_n(rrst_n), .cfg_ports(cfg_ports), .cfg_qtr(cfg_qtr),
        .rd_en(rd_en), .rd_port(rd_port), .rd_width(rd_width),
        .wgray_s(wgray_s), .rgray(rgray),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .rd_data(rd_data), .rd_ctl(rd_ctl),
        .rd_valid(rd_valid), .rd_refused(rd_refused),
        .stat_level(stat_level), .stat_empty(stat_empty)
    );
endmodule

// File: tb/sim_vfb_bank.sv
module sim_vfb_bank;
    logic         clk = 1'b0;
    logic         wrst_n, rrst_n;
    logic [1:0]   cfg_ports;
    logic         cfg_qtr;
    logic         wr_en;
    logic [2:0]   wr_port;
    logic [31:0]  wr_data;
    logic [7:0]   wr_ctl;
    logic [7:0]   wr_full, wr_ovf;
    logic         rd_en;
    logic [2:0]   rd_port;
    logic [1:0]   rd_width;
    logic [127:0] rd_data;
    logic [31:0]  rd_ctl;
    logic         rd_valid, rd_refused;
    logic [6:0]   stat_level;
    logic         stat_empty;

    int total = 0;
    int bad   = 0;
    int wcnt [8];
    int rcnt [8];
    int psz, nact;
    logic [127:0] exp_data;
    logic [31:0]  exp_ctl;

    // port, width
    localparam logic [4:0] VEC [12] = '{
        5'b000_01, 5'b000_10, 5'b000_00, 5'b001_10, 5'b001_11, 5'b001_00,
        5'b010_01, 5'b010_00, 5'b011_10, 5'b011_01, 5'b011_00, 5'b000_01
    };

    always #10 clk = ~clk;

    vfb_bank u0 (
        .wclk(clk), .wrst_n(wrst_n), .rclk(clk), .rrst_n(rrst_n),
        .cfg_ports(cfg_ports), .cfg_qtr(cfg_qtr),
        .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data), .wr_ctl(wr_ctl),
        .wr_full(wr_full), .wr_ovf(wr_ovf),
        .rd_en(rd_en), .rd_port(rd_port), .rd_width(rd_width),
        .rd_data(rd_data), .rd_ctl(rd_ctl), .rd_valid(rd_valid), .rd_refused(rd_refused),
        .stat_level(stat_level), .stat_empty(stat_empty)
    );

    function automatic logic [31:0] wdat(input int p, input int i);
        return 32'(p * 256 + i);
    endfunction

    function automatic logic [7:0] wctl(input int p, input int i);
        return 8'(p * 32 + i);
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] c, input logic q);
        @(negedge clk);
        wrst_n = 1'b0; rrst_n = 1'b0; cfg_ports = c; cfg_qtr = q;
        wr_en = 1'b0; rd_en = 1'b0; rd_port = 3'd0; rd_width = 2'd0;
        wr_port = 3'd0; wr_data = '0; wr_ctl = '0;
        repeat (3) @(negedge clk);
        wrst_n = 1'b1; rrst_n = 1'b1;
        psz = 64 >> c;
        nact = 1 << c;
        for (int p = 0; p < 8; p++) begin wcnt[p] = 0; rcnt[p] = 0; end
        exp_data = '0; exp_ctl = '0;
        @(negedge clk);
    endtask

    task automatic push(input int p, input int n);
        for (int i = 0; i < n; i++) begin
            wr_en = 1'b1; wr_port = 3'(p);
            wr_data = wdat(p, wcnt[p]); wr_ctl = wctl(p, wcnt[p]);
            if (p < nact && (wcnt[p] - rcnt[p]) < psz) wcnt[p]++;
            @(negedge clk);
        end
        wr_en = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic poll(input int p, input int lvl, input logic emp, input string tag);
        rd_en = 1'b0; rd_port = 3'(p);
        #1;
        chk({tag, " level"}, 128'(stat_level), 128'(lvl));
        chk({tag, " empty"}, 128'(stat_empty), 128'(emp));
    endtask

    task automatic pull(input int p, input int w);
        int need, lvl;
        logic ok;
        need = (w == 0) ? 1 : (w == 1) ? 2 : 4;
        lvl  = wcnt[p] - rcnt[p];
        ok   = lvl >= need;
        rd_en = 1'b1; rd_port = 3'(p); rd_width = 2'(w);
        @(negedge clk);
        rd_en = 1'b0;
        if (ok) begin
            for (int i = 0; i < 4; i++) begin
                exp_data[i*32 +: 32] = (i < need) ? wdat(p, rcnt[p] + i) : 32'd0;
                exp_ctl[i*8 +: 8]    = (i < need) ? wctl(p, rcnt[p] + i) : 8'd0;
            end
            rcnt[p] += need;
        end
        chk("R4 valid", 128'(rd_valid), 128'(ok));
        chk("R5 refused", 128'(rd_refused), 128'(!ok));
        chk(ok ? "R4 data" : "R5 data held", rd_data, exp_data);
        chk(ok ? "R4 ctl" : "R5 ctl held", 128'(rd_ctl), 128'(exp_ctl));
        chk("R6 level after read", 128'(stat_level), 128'(wcnt[p] - rcnt[p]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9 reset state, eight ports of eight entries
        do_reset(2'd3, 1'b0);
        chk("R9 level", 128'(stat_level), 128'd0);
        chk("R9 empty", 128'(stat_empty), 128'd1);
        chk("R9 full", 128'(wr_full), 128'd0);
        chk("R9 ovf", 128'(wr_ovf), 128'd0);
        chk("R9 flags", 128'({rd_valid, rd_refused}), 128'd0);
        chk("R9 data", rd_data, 128'd0);

        push(0, 5); push(1, 8); push(2, 1); push(3, 3);
        chk("R3 full", 128'(wr_full), 128'h02);
        push(1, 1);
        chk("R3 ovf", 128'(wr_ovf), 128'h02);
        poll(1, 8, 1'b0, "R3 dropped");
        poll(0, 5, 1'b0, "R1");
        poll(2, 1, 1'b0, "R7 exact");
        poll(4, 0, 1'b1, "R7 exact");

        // table of read requests
        for (int k = 0; k < 12; k++) pull(int'(VEC[k][4:2]), int'(VEC[k][1:0]));

        chk("R3 sticky", 128'(wr_ovf), 128'h02);
        chk("R8 full cleared", 128'(wr_full), 128'd0);

        // R6 polling consumes nothing
        push(5, 3);
        repeat (6) begin poll(5, 3, 1'b0, "R6 poll"); @(negedge clk); end
        chk("R6 idle flags", 128'({rd_valid, rd_refused}), 128'd0);
        pull(5, 0);

        // same cycle: write to full port 6 while reading it
        push(6, 8);
        chk("R3 full6", 128'(wr_full[6]), 128'd1);
        rd_en = 1'b1; rd_port = 3'd6; rd_width = 2'd0;
        wr_en = 1'b1; wr_port = 3'd6; wr_data = 32'hDEAD_BEEF; wr_ctl = 8'hEE;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        chk("R4 same-cycle valid", 128'(rd_valid), 128'd1);
        chk("R4 same-cycle data", rd_data, 128'(wdat(6, 0)));
        chk("R3 same-cycle ovf", 128'(wr_ovf[6]), 128'd1);
        rcnt[6] = 1;
        repeat (5) @(negedge clk);
        poll(6, 7, 1'b0, "R8 settle");
        chk("R8 full6 clear", 128'(wr_full[6]), 128'd0);

        // two ports of 32 entries
        do_reset(2'd1, 1'b0);
        chk("R9 ovf after reset", 128'(wr_ovf), 128'd0);
        push(5, 2);
        poll(5, 0, 1'b1, "R2");
        poll(0, 0, 1'b1, "R2");
        poll(1, 0, 1'b1, "R2");
        chk("R2 ovf", 128'(wr_ovf), 128'd0);
        push(1, 4); push(0, 31);
        chk("R1 not full at 31", 128'(wr_full), 128'd0);
        push(0, 1);
        chk("R1 full at 32", 128'(wr_full), 128'h01);
        pull(1, 2);
        chk("R1 port1 first", 128'(rd_data[31:0]), 128'(wdat(1, 0)));
        pull(0, 0);
        chk("R1 port0 first", 128'(rd_data[31:0]), 128'(wdat(0, 0)));

        // quarter mode, eight entries, quarter is two
        do_reset(2'd3, 1'b1);
        poll(4, 0, 1'b1, "R7 quarter");
        rd_port = 3'd4;
        wr_en = 1'b1; wr_port = 3'd4; wr_data = wdat(4, 0); wr_ctl = wctl(4, 0);
        wcnt[4] = 1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 four-edge latency", 128'(stat_level), 128'd1);
        poll(4, 1, 1'b1, "R7 quarter");
        push(4, 1);
        poll(4, 2, 1'b0, "R7 quarter");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule